// File: doc/BRIEF.md
# Cipher Engine Control and State Loader

This block is the byte-wide register front end of a block-cipher accelerator. A host reaches it through a small read/write port with four addresses: a control register, a status register, a state data window and a key data window. Each data window walks a 16-byte memory through its own read pointer and write pointer. Each pointer advances by one on every access and wraps back to zero. With the XOR-load bit set, a byte written to the state memory is combined with the byte already stored at that position.

Processing starts in one of two ways. The host can set the start bit, or the block can start itself when auto-start was armed before a full state load and all four pointers were at zero. A stand-in engine with a fixed latency replaces the real cipher rounds. It combines state and key byte by byte and rotates the result by one byte in a direction that depends on the mode. When it finishes, it writes the result back into the state memory, so the host reads the result through the same window. Clearing the start bit aborts a run. Touching either memory during a run is reported as an error. A self-clearing soft reset returns everything to its initial state.

Top module: `cipher_ctrl_loader`

## Requirements
- R1: After the asynchronous reset, the control register (address 0) and the status register (address 1) both read 0x00.
- R2: In the control register, bit 7 is start/run, bit 6 auto-start, bit 5 soft reset, bit 4 direction (1 = decrypt) and bit 2 XOR-load. Bits 3, 1 and 0 ignore writes and read as 0, so writing 0x5F reads back 0x54.
- R3: The state window (address 2) and the key window (address 3) each have a 4-bit read pointer and a 4-bit write pointer. A pointer advances by one on each read or write of its window and wraps from 15 to 0. A 17th key write overwrites key byte 0.
- R4: While XOR-load is 1, a state write stores the old byte XOR the written byte. While it is 0, the written byte replaces the old one.
- R5: When the host writes 1 to start while idle, the start bit reads 1 for exactly 20 cycles after the write edge. It then reads 0, and status bit 0 (done) is set. In encrypt mode, result byte i is m[(i+1) mod 16], where m[j] = state[j] XOR key[j].
- R6: In decrypt mode, result byte i is m[(i+15) mod 16]. The direction is captured when the run starts, so a later direction change has no effect on that run.
- R7: Writing 1 to status bit 0 clears done, and writing 1 to status bit 7 clears error. Writing 0 to either bit leaves it unchanged.
- R8: Writing 0 to start during a run stops the run in the next cycle. It sets neither the done flag nor the error flag.
- R9: Any access to the state or key window during a run sets status bit 7 (error) and stops the run without setting done. The access itself is ignored, so the memories and pointers keep their values.
- R10: If auto-start is 1 and all four pointers are 0 when the first state byte is written, the 16th state write starts a run. If any pointer is nonzero at that first write, no run starts.
- R11: Writing 1 to control bit 5 makes that bit read 1 for one cycle. On the next edge, all control bits, flags, pointers and both memories return to 0.
- R12: At completion, the state read pointer returns to 0, so the next 16 state reads return the result from byte 0 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| rd_en_i | input | 1 | Read strobe; advances the pointer of a data window |
| addr_i | input | 2 | 0 control, 1 status, 2 state window, 3 key window |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational, no side effect without rd_en_i) |

## Verification
On every cycle, the assertions check these properties: pointer stepping and wrap on accepted state writes, key pointers holding still when the key window is idle, the bound on run length, the run ending when done rises, abort leaving both flags untouched, errors raised by accesses during a run, and the complete clearing one cycle after a soft reset. Other behaviour depends on data values and on sequences, so only the bench scenarios can show it. This covers the byte values of the encrypt and decrypt results, XOR accumulation, readback from byte 0 after completion, direction capture at start, and whether auto-start fires or stays quiet depending on when it was armed.

// File: rtl/cipher_ctrl_pkg.sv
package cipher_ctrl_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_STAT  = 2'd1,
    ADDR_STATE = 2'd2,
    ADDR_KEY   = 2'd3
  } addr_e;

  localparam int unsigned C_RUN  = 7;
  localparam int unsigned C_AUTO = 6;
  localparam int unsigned C_SRST = 5;
  localparam int unsigned C_DEC  = 4;
  localparam int unsigned C_XOR  = 2;
  localparam int unsigned S_DONE = 0;
  localparam int unsigned S_ERR  = 7;
endpackage

// File: rtl/cipher_ctrl_regs.sv
module cipher_ctrl_regs
  import cipher_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic              stat_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              done_evt_i,
  input  logic              err_evt_i,
  output logic              auto_o,
  output logic              srst_o,
  output logic              dec_o,
  output logic              xor_o,
  output logic              done_o,
  output logic              err_o,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [BYTE_W-1:0] stat_o
);
  logic auto_q, srst_q, dec_q, xor_q, done_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_q <= 1'b0;
      srst_q <= 1'b0;
      dec_q  <= 1'b0;
      xor_q  <= 1'b0;
    end else if (srst_q) begin
      auto_q <= 1'b0;
      srst_q <= 1'b0;
      dec_q  <= 1'b0;
      xor_q  <= 1'b0;
    end else if (ctrl_wr_i) begin
      auto_q <= wdata_i[C_AUTO];
      srst_q <= wdata_i[C_SRST];
      dec_q  <= wdata_i[C_DEC];
      xor_q  <= wdata_i[C_XOR];
    end else begin
      srst_q <= 1'b0;
    end
  end

  // set wins over write-1-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (srst_q) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (done_evt_i)                         done_q <= 1'b1;
      else if (stat_wr_i && wdata_i[S_DONE])  done_q <= 1'b0;
      if (err_evt_i)                          err_q  <= 1'b1;
      else if (stat_wr_i && wdata_i[S_ERR])   err_q  <= 1'b0;
    end
  end

  always_comb begin
    ctrl_o         = '0;
    ctrl_o[C_RUN]  = busy_i;
    ctrl_o[C_AUTO] = auto_q;
    ctrl_o[C_SRST] = srst_q;
    ctrl_o[C_DEC]  = dec_q;
    ctrl_o[C_XOR]  = xor_q;
    stat_o         = '0;
    stat_o[S_DONE] = done_q;
    stat_o[S_ERR]  = err_q;
  end

  assign auto_o = auto_q;
  assign srst_o = srst_q;
  assign dec_o  = dec_q;
  assign xor_o  = xor_q;
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/cipher_byte_mem.sv
module cipher_byte_mem
  import cipher_ctrl_pkg::*;
#(
  parameter int unsigned NB = 16,
  localparam int unsigned PW = $clog2(NB)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic                         wr_i,
  input  logic                         rd_i,
  input  logic                         xor_en_i,
  input  logic [BYTE_W-1:0]            wdata_i,
  input  logic                         load_i,
  input  logic [NB-1:0][BYTE_W-1:0]    load_data_i,
  input  logic                         rptr_clr_i,
  output logic [BYTE_W-1:0]            rdata_o,
  output logic [PW-1:0]                wptr_o,
  output logic [PW-1:0]                rptr_o,
  output logic [NB-1:0][BYTE_W-1:0]    mem_o
);
  localparam logic [PW-1:0] LAST = PW'(NB - 1);

  logic [BYTE_W-1:0] mem_q [NB];
  logic [PW-1:0]     wptr_q, rptr_q;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (wr_i) wptr_q <= step(wptr_q);
      if (rptr_clr_i)  rptr_q <= '0;
      else if (rd_i)   rptr_q <= step(rptr_q);
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[i] <= '0;
      end else if (clr_i) begin
        mem_q[i] <= '0;
      end else if (load_i) begin
        mem_q[i] <= load_data_i[i];
      end else if (wr_i && (wptr_q == PW'(i))) begin
        mem_q[i] <= xor_en_i ? (mem_q[i] ^ wdata_i) : wdata_i;
      end
    end
    assign mem_o[i] = mem_q[i];
  end

  assign rdata_o = mem_q[rptr_q];
  assign wptr_o  = wptr_q;
  assign rptr_o  = rptr_q;
endmodule

// File: rtl/cipher_stub_engine.sv
module cipher_stub_engine
  import cipher_ctrl_pkg::*;
#(
  parameter int unsigned NB  = 16,
  parameter int unsigned LAT = 20,
  localparam int unsigned CW = $clog2(LAT + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      start_i,
  input  logic                      dec_i,
  input  logic [NB-1:0][BYTE_W-1:0] state_i,
  input  logic [NB-1:0][BYTE_W-1:0] key_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [NB-1:0][BYTE_W-1:0] result_o
);
  logic          busy_q, dec_q;
  logic [CW-1:0] cnt_q;
  logic [NB-1:0][BYTE_W-1:0] mix;

  assign done_o = busy_q && (cnt_q == CW'(LAT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      dec_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      dec_q  <= dec_i;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (done_o) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_mix
    localparam int unsigned NX = (i + 1) % NB;
    localparam int unsigned PV = (i + NB - 1) % NB;
    assign mix[i]      = state_i[i] ^ key_i[i];
    assign result_o[i] = dec_q ? mix[PV] : mix[NX];
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/cipher_ctrl_loader.sv
module cipher_ctrl_loader
  import cipher_ctrl_pkg::*;
#(
  parameter int unsigned NB_P  = 16,
  parameter int unsigned LAT_P = 20,
  localparam int unsigned PW   = $clog2(NB_P)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam logic [PW-1:0] LAST = PW'(NB_P - 1);

  logic ctrl_wr, stat_wr, st_sel, ky_sel, st_acc, ky_acc;
  logic busy, eng_done, eng_clr, done_evt, err_evt, abort;
  logic auto_q, srst, dec_q, xor_q, done_flag, err_flag;
  logic man_start, auto_start, start, start_dec, arm_q;
  logic st_wr, st_rd, ky_wr, ky_rd;
  logic [BYTE_W-1:0] ctrl_rd, stat_rd, st_rdata, ky_rdata;
  logic [PW-1:0] s_wptr, s_rptr, k_wptr, k_rptr;
  logic [NB_P-1:0][BYTE_W-1:0] st_mem, ky_mem, result;

  assign ctrl_wr = wr_en_i && (addr_i == ADDR_CTRL);
  assign stat_wr = wr_en_i && (addr_i == ADDR_STAT);
  assign st_sel  = (addr_i == ADDR_STATE);
  assign ky_sel  = (addr_i == ADDR_KEY);
  assign st_acc  = (wr_en_i || rd_en_i) && st_sel;
  assign ky_acc  = (wr_en_i || rd_en_i) && ky_sel;

  // memory traffic only while idle and not in soft reset
  assign st_wr = wr_en_i && st_sel && !busy && !srst;
  assign st_rd = rd_en_i && st_sel && !busy && !srst;
  assign ky_wr = wr_en_i && ky_sel && !busy && !srst;
  assign ky_rd = rd_en_i && ky_sel && !busy && !srst;

  assign err_evt  = busy && (st_acc || ky_acc) && !srst;
  assign abort    = busy && ctrl_wr && !wdata_i[C_RUN];
  assign eng_clr  = srst || abort || err_evt;
  assign done_evt = eng_done && !eng_clr;

  assign man_start  = ctrl_wr && wdata_i[C_RUN] && !busy && !srst;
  assign auto_start = st_wr && (s_wptr == LAST) && arm_q && auto_q;
  assign start      = man_start || auto_start;
  assign start_dec  = man_start ? wdata_i[C_DEC] : dec_q;

  // auto-start armed by the conditions seen at the first byte of a load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
    end else if (srst) begin
      arm_q <= 1'b0;
    end else if (st_wr) begin
      if (s_wptr == '0)
        arm_q <= auto_q && (s_rptr == '0) && (k_wptr == '0) && (k_rptr == '0);
      else if (s_wptr == LAST)
        arm_q <= 1'b0;
    end
  end

  cipher_ctrl_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_wr_i  (ctrl_wr),
    .stat_wr_i  (stat_wr),
    .wdata_i    (wdata_i),
    .busy_i     (busy),
    .done_evt_i (done_evt),
    .err_evt_i  (err_evt),
    .auto_o     (auto_q),
    .srst_o     (srst),
    .dec_o      (dec_q),
    .xor_o      (xor_q),
    .done_o     (done_flag),
    .err_o      (err_flag),
    .ctrl_o     (ctrl_rd),
    .stat_o     (stat_rd)
  );

  cipher_byte_mem #(.NB(NB_P)) u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (srst),
    .wr_i        (st_wr),
    .rd_i        (st_rd),
    .xor_en_i    (xor_q),
    .wdata_i     (wdata_i),
    .load_i      (done_evt),
    .load_data_i (result),
    .rptr_clr_i  (done_evt),
    .rdata_o     (st_rdata),
    .wptr_o      (s_wptr),
    .rptr_o      (s_rptr),
    .mem_o       (st_mem)
  );

  cipher_byte_mem #(.NB(NB_P)) u_key (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (srst),
    .wr_i        (ky_wr),
    .rd_i        (ky_rd),
    .xor_en_i    (1'b0),
    .wdata_i     (wdata_i),
    .load_i      (1'b0),
    .load_data_i ('0),
    .rptr_clr_i  (1'b0),
    .rdata_o     (ky_rdata),
    .wptr_o      (k_wptr),
    .rptr_o      (k_rptr),
    .mem_o       (ky_mem)
  );

  cipher_stub_engine #(.NB(NB_P), .LAT(LAT_P)) u_engine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (eng_clr),
    .start_i  (start),
    .dec_i    (start_dec),
    .state_i  (st_mem),
    .key_i    (ky_mem),
    .busy_o   (busy),
    .done_o   (eng_done),
    .result_o (result)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL:  rdata_o = ctrl_rd;
      ADDR_STAT:  rdata_o = stat_rd;
      ADDR_STATE: rdata_o = st_rdata;
      default:    rdata_o = ky_rdata;
    endcase
  end
endmodule

// File: rtl/cipher_ctrl_loader_chk.sv
module cipher_ctrl_loader_chk #(
  parameter int unsigned NB  = 16,
  parameter int unsigned LAT = 20,
  localparam int unsigned PW = $clog2(NB),
  localparam int unsigned CW = $clog2(LAT + 2)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic [1:0]    addr_i,
  input logic [7:0]    wdata_i,
  input logic          busy_i,
  input logic          srst_i,
  input logic          done_i,
  input logic          err_i,
  input logic [PW-1:0] s_wptr_i,
  input logic [PW-1:0] s_rptr_i,
  input logic [PW-1:0] k_wptr_i,
  input logic [PW-1:0] k_rptr_i
);
  logic [CW-1:0] run_cnt;
  logic          acc_data;

  assign acc_data = (wr_en_i || rd_en_i) && addr_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt <= '0;
    else if (busy_i) run_cnt <= run_cnt + 1'b1;
    else             run_cnt <= '0;
  end

  assert_wptr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd2 && !busy_i && !srst_i) |=>
      (s_wptr_i == (($past(s_wptr_i) == PW'(NB - 1)) ? '0 : $past(s_wptr_i) + 1'b1)));

  assert_key_ptr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(addr_i == 2'd3 && (wr_en_i || rd_en_i)) && !srst_i) |=>
      ($stable(k_wptr_i) && $stable(k_rptr_i)));

  assert_run_bounded_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (run_cnt < CW'(LAT)));

  assert_done_ends_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> !busy_i);

  assert_abort_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_en_i && !rd_en_i && addr_i == 2'd0 && !wdata_i[7] && !srst_i) |=>
      (!busy_i && $stable(done_i) && $stable(err_i)));

  assert_access_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && acc_data && !srst_i) |=> (err_i && !busy_i && !done_i ||
                                         err_i && !busy_i && $past(done_i)));

  assert_soft_reset_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (!srst_i && !busy_i && !done_i && !err_i && s_wptr_i == '0 &&
                s_rptr_i == '0 && k_wptr_i == '0 && k_rptr_i == '0));
endmodule

bind cipher_ctrl_loader cipher_ctrl_loader_chk #(.NB(NB_P), .LAT(LAT_P)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .busy_i   (busy),
  .srst_i   (srst),
  .done_i   (done_flag),
  .err_i    (err_flag),
  .s_wptr_i (s_wptr),
  .s_rptr_i (s_rptr),
  .k_wptr_i (k_wptr),
  .k_rptr_i (k_rptr)
);

// File: tb/cipher_ctrl_loader_bench.sv
module cipher_ctrl_loader_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;

  int n_chk = 0, n_err = 0;
  logic [7:0] pa [16], pb [16], pk [16], exp_m [16];

  always #5 clk = ~clk;

  cipher_ctrl_loader u_cipher_ctrl_loader (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic soft_reset();
    bus_wr(2'd0, 8'h20);
    @(negedge clk);
  endtask

  task automatic load_key();
    for (int i = 0; i < 16; i++) bus_wr(2'd3, pk[i]);
  endtask

  task automatic load_state_a();
    for (int i = 0; i < 16; i++) bus_wr(2'd2, pa[i]);
  endtask

  task automatic calc_exp(input bit dec);
    logic [7:0] m [16];
    for (int i = 0; i < 16; i++) m[i] = pa[i] ^ pk[i];
    for (int i = 0; i < 16; i++) exp_m[i] = dec ? m[(i + 15) % 16] : m[(i + 1) % 16];
  endtask

  task automatic read_cmp(input string tag);
    logic [7:0] d;
    for (int i = 0; i < 16; i++) begin
      bus_rd(2'd2, d);
      check(tag, d, exp_m[i]);
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    @(negedge clk);
    peek(2'd0, d); check("R1 ctrl after reset", d, 8'h00);
    peek(2'd1, d); check("R1 status after reset", d, 8'h00);
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    bus_wr(2'd0, 8'h5F);
    peek(2'd0, d); check("R2 reserved bits read 0", d, 8'h54);
    bus_wr(2'd0, 8'h00);
    peek(2'd0, d); check("R2 ctrl cleared", d, 8'h00);
  endtask

  task automatic t_key_wrap();
    logic [7:0] d;
    soft_reset();
    for (int i = 0; i < 17; i++) bus_wr(2'd3, 8'hA0 + 8'(i));
    for (int i = 0; i < 17; i++) begin
      bus_rd(2'd3, d);
      check("R3 key wrap readback", d, (i % 16 == 0) ? 8'hB0 : 8'hA0 + 8'(i));
    end
  endtask

  task automatic t_xor_load();
    soft_reset();
    load_state_a();
    bus_wr(2'd0, 8'h04);
    for (int i = 0; i < 16; i++) bus_wr(2'd2, pb[i]);
    bus_wr(2'd0, 8'h00);
    for (int i = 0; i < 16; i++) exp_m[i] = pa[i] ^ pb[i];
    read_cmp("R4 xor accumulate");
    for (int i = 0; i < 16; i++) bus_wr(2'd2, pb[i]);
    for (int i = 0; i < 16; i++) exp_m[i] = pb[i];
    read_cmp("R4 overwrite");
  endtask

  task automatic t_encrypt();
    logic [7:0] d;
    int n;
    soft_reset();
    load_key();
    load_state_a();
    for (int i = 0; i < 3; i++) bus_rd(2'd2, d);
    bus_wr(2'd0, 8'h80);
    n = 0;
    for (int k = 0; k < 40; k++) begin
      peek(2'd0, d);
      if (!d[7]) break;
      n++;
      @(negedge clk);
    end
    check("R5 run length", 8'(n), 8'd20);
    peek(2'd1, d); check("R5 done flag", d, 8'h01);
    calc_exp(1'b0);
    read_cmp("R5 R12 encrypt result from byte 0");
    bus_wr(2'd1, 8'h00);
    peek(2'd1, d); check("R7 write 0 keeps done", d, 8'h01);
    bus_wr(2'd1, 8'h01);
    peek(2'd1, d); check("R7 write 1 clears done", d, 8'h00);
  endtask

  task automatic t_decrypt();
    logic [7:0] d;
    soft_reset();
    load_key();
    load_state_a();
    bus_wr(2'd0, 8'h90);
    bus_wr(2'd0, 8'h80);
    repeat (25) @(negedge clk);
    peek(2'd1, d); check("R6 done flag", d, 8'h01);
    calc_exp(1'b1);
    read_cmp("R6 decrypt result, direction held");
  endtask

  task automatic t_abort();
    logic [7:0] d;
    soft_reset();
    load_key();
    load_state_a();
    bus_wr(2'd0, 8'h80);
    repeat (5) @(negedge clk);
    bus_wr(2'd0, 8'h00);
    peek(2'd0, d); check("R8 start clear after abort", d, 8'h00);
    repeat (30) @(negedge clk);
    peek(2'd1, d); check("R8 no flags after abort", d, 8'h00);
  endtask

  task automatic t_busy_access();
    logic [7:0] d;
    soft_reset();
    load_key();
    load_state_a();
    bus_wr(2'd0, 8'h80);
    repeat (3) @(negedge clk);
    bus_wr(2'd2, 8'hAA);
    peek(2'd0, d); check("R9 run stopped by error", d, 8'h00);
    peek(2'd1, d); check("R9 error flag", d, 8'h80);
    repeat (25) @(negedge clk);
    peek(2'd1, d); check("R9 no done after error", d, 8'h80);
    bus_wr(2'd1, 8'h80);
    peek(2'd1, d); check("R7 write 1 clears error", d, 8'h00);
    for (int i = 0; i < 16; i++) exp_m[i] = pa[i];
    read_cmp("R9 state untouched");
  endtask

  task automatic t_auto();
    logic [7:0] d;
    soft_reset();
    bus_wr(2'd0, 8'h40);
    load_key();
    load_state_a();
    peek(2'd0, d); check("R10 auto start fired", d, 8'hC0);
    repeat (20) @(negedge clk);
    peek(2'd1, d); check("R10 auto run done", d, 8'h01);
    calc_exp(1'b0);
    read_cmp("R10 auto result");
    soft_reset();
    bus_wr(2'd0, 8'h40);
    bus_wr(2'd3, 8'h11);
    load_state_a();
    peek(2'd0, d); check("R10 no auto start with key ptr nonzero", d, 8'h40);
    repeat (25) @(negedge clk);
    peek(2'd1, d); check("R10 no done without auto start", d, 8'h00);
  endtask

  task automatic t_soft_reset();
    logic [7:0] d;
    bus_wr(2'd0, 8'h00);
    load_key();
    load_state_a();
    bus_wr(2'd3, 8'h77);
    bus_wr(2'd0, 8'h34);
    peek(2'd0, d); check("R11 reset bit visible one cycle", d, 8'h34);
    @(negedge clk);
    peek(2'd0, d); check("R11 ctrl cleared", d, 8'h00);
    bus_rd(2'd2, d); check("R11 state memory cleared", d, 8'h00);
    bus_rd(2'd3, d); check("R11 key memory cleared", d, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      pa[i] = 8'(i * 7 + 3);
      pb[i] = 8'(8'h5C ^ (i * 13));
      pk[i] = 8'(8'hE1 - i * 9);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reserved();
    t_key_wrap();
    t_xor_load();
    t_encrypt();
    t_decrypt();
    t_abort();
    t_busy_access();
    t_auto();
    t_soft_reset();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule